// File: doc/BRIEF.md
# Work-Item Dispatch Controller

This block sits beside one multithreaded vector core. It turns a kernel launch into a stream of work items and runs each item on a hardware thread of the core. A host programs the launch through an AXI4-Lite slave. It writes the kernel entry address, the three grid extents and the three work-group extents, then rings a doorbell register. The controller walks the grid and hands each item to an idle thread. It does this by raising that thread's enable and latching the item's coordinates and the group dimensions for that thread.

Each item spans sixteen adjacent X ids, one per vector lane. The X coordinate therefore steps by sixteen per item. A thread reads its own coordinates and group size over a small uncached read port, so the data caches are not involved. When the thread finishes, it drops its enable through a halt strobe. The controller gives the freed thread the next pending item. A single-cycle completion interrupt marks the end of the launch, once the last item has been handed out and every thread is idle again.

Top module: `witem_dispatch`

## Requirements
- R1: AXI4-Lite registers are word-addressed by address bits [5:2]. Index 0 is the entry address, 1 to 3 are grid X/Y/Z, 4 to 6 are group X/Y/Z, 7 is the doorbell and 8 is status (bit 0 busy, bit 1 error). Writes honour byte strobes. The write response and the read data each come one cycle after the handshake, with response code 0.
- R2: A doorbell write while idle starts a launch, and status bit 0 reads 1 until the launch completes.
- R3: Items are issued with X advancing by 16 from 0 while below grid X, then Y, then Z. The launch issues exactly ceil(gridX/16)*gridY*gridZ items.
- R4: An item goes to the lowest-numbered idle thread. At most one thread starts per cycle. The chosen thread's `thr_en` bit rises and its `thr_start` bit pulses for one cycle.
- R5: A pulse on `thr_halt[i]` clears `thr_en[i]` on the next edge, and the thread becomes eligible for the next item.
- R6: An IO read of thread t, field f returns data one cycle later with `io_rvalid`. The fields are 0 = item X, 1 = item Y, 2 = item Z, 3 to 5 = group X/Y/Z, and any other field reads 0.
- R7: `done_irq` pulses for exactly one cycle once all items have been issued and all threads are idle. Busy reads 0 afterwards.
- R8: A doorbell write during a launch does not restart it and sets status bit 1. Bit 1 stays set until any write to the status register.
- R9: Writes to configuration registers during a launch are ignored.
- R10: A launch with any grid extent of zero starts no thread and still raises `done_irq` once.
- R11: `start_pc` presents the programmed entry address while threads run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | 6 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 6 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| thr_en | output | NTHR | Per-thread run enable |
| thr_start | output | NTHR | One-cycle pulse when a thread gets an item |
| thr_halt | input | NTHR | Thread retire strobe |
| start_pc | output | 32 | Kernel entry address |
| io_rd | input | 1 | Metadata read request |
| io_tid | input | TIDW | Thread to read |
| io_fld | input | 3 | Field to read |
| io_rdata | output | 32 | Metadata read data |
| io_rvalid | output | 1 | Metadata read data valid |
| done_irq | output | 1 | Launch-complete pulse |

## Verification
Bus responses and metadata read data are due one cycle after the accepting edge, so every bench task samples them at the falling edge right after that edge. A thread start appears one cycle after an idle thread and a pending item coincide. The monitor samples each falling edge and checks the started thread against a thread-occupancy model, which is updated only after a retire has taken effect. The completion pulse follows the edge that idles the last thread. The bench waits for it, then waits a few more cycles and confirms that exactly one pulse arrived and that every expected item had been consumed.

// File: rtl/wdc_pkg.sv
// Shared types for the work-item dispatch controller.
// Assumes 32-bit registers and a 6-bit byte address on the host bus.
package wdc_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 6;

    typedef enum logic [3:0] {
        RA_PC   = 4'd0,
        RA_GX   = 4'd1,
        RA_GY   = 4'd2,
        RA_GZ   = 4'd3,
        RA_LX   = 4'd4,
        RA_LY   = 4'd5,
        RA_LZ   = 4'd6,
        RA_BELL = 4'd7,
        RA_STAT = 4'd8
    } reg_idx_e;

    typedef struct packed {
        logic [WORD_W-1:0] x;
        logic [WORD_W-1:0] y;
        logic [WORD_W-1:0] z;
    } triple_t;

    typedef struct packed {
        logic [WORD_W-1:0] pc;
        triple_t           grid;
        triple_t           grp;
    } disp_cfg_t;
endpackage

// File: rtl/wdc_regs.sv
// Host-facing AXI4-Lite register file: holds the launch descriptor and
// raises a start strobe on an accepted doorbell.
// Assumes one outstanding transaction per channel; config is frozen while busy.
module wdc_regs
    import wdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [WORD_W-1:0] wdata,
    input  logic [3:0]        wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [WORD_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic              busy,
    output disp_cfg_t         cfg,
    output logic              go
);
    logic       wr_fire, rd_fire, err;
    reg_idx_e   widx, ridx;
    logic [WORD_W-1:0] rmux;
    logic       unused_addr;

    assign unused_addr = ^{awaddr[1:0], araddr[1:0]};
    assign widx    = reg_idx_e'(awaddr[5:2]);
    assign ridx    = reg_idx_e'(araddr[5:2]);
    assign wr_fire = awvalid && wvalid && !bvalid;
    assign awready = wr_fire;
    assign wready  = wr_fire;
    assign rd_fire = arvalid && !rvalid;
    assign arready = !rvalid;
    assign bresp   = 2'b00;
    assign rresp   = 2'b00;
    assign go      = wr_fire && (widx == RA_BELL) && !busy;

    // Byte-lane merge of new write data into an old register value.
    function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] old_v,
                                                input logic [WORD_W-1:0] new_v,
                                                input logic [3:0]        strb);
        logic [WORD_W-1:0] r;
        r = old_v;
        for (int b = 0; b < 4; b++)
            if (strb[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        return r;
    endfunction

    // Write channel: update descriptor, error flag and write response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg    <= '0;
            err    <= 1'b0;
            bvalid <= 1'b0;
        end else if (wr_fire) begin
            bvalid <= 1'b1;
            case (widx)
                RA_PC:   if (!busy) cfg.pc     <= merge(cfg.pc,     wdata, wstrb);
                RA_GX:   if (!busy) cfg.grid.x <= merge(cfg.grid.x, wdata, wstrb);
                RA_GY:   if (!busy) cfg.grid.y <= merge(cfg.grid.y, wdata, wstrb);
                RA_GZ:   if (!busy) cfg.grid.z <= merge(cfg.grid.z, wdata, wstrb);
                RA_LX:   if (!busy) cfg.grp.x  <= merge(cfg.grp.x,  wdata, wstrb);
                RA_LY:   if (!busy) cfg.grp.y  <= merge(cfg.grp.y,  wdata, wstrb);
                RA_LZ:   if (!busy) cfg.grp.z  <= merge(cfg.grp.z,  wdata, wstrb);
                RA_BELL: if (busy)  err <= 1'b1;
                RA_STAT: err <= 1'b0;
                default: ;
            endcase
        end else if (bvalid && bready) begin
            bvalid <= 1'b0;
        end
    end

    // Read data selection by register index.
    always_comb begin
        case (ridx)
            RA_PC:   rmux = cfg.pc;
            RA_GX:   rmux = cfg.grid.x;
            RA_GY:   rmux = cfg.grid.y;
            RA_GZ:   rmux = cfg.grid.z;
            RA_LX:   rmux = cfg.grp.x;
            RA_LY:   rmux = cfg.grp.y;
            RA_LZ:   rmux = cfg.grp.z;
            RA_STAT: rmux = {{(WORD_W-2){1'b0}}, err, busy};
            default: rmux = '0;
        endcase
    end

    // Read channel: register the selected word one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_fire) begin
            rvalid <= 1'b1;
            rdata  <= rmux;
        end else if (rvalid && rready) begin
            rvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/wdc_walker.sv
// Grid walker: steps the current item position X-major (by LANES), then Y,
// then Z, and tracks launch busy / completion.
// Assumes go is only asserted while not busy.
module wdc_walker
    import wdc_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go,
    input  triple_t grid,
    input  logic    take,
    input  logic    all_idle,
    output logic    have,
    output triple_t pos,
    output logic    busy,
    output logic    done
);
    localparam logic [WORD_W:0] STEP = (WORD_W+1)'(LANES);

    logic [WORD_W:0] nx, ny, nz;
    logic x_wrap, y_wrap, z_wrap;

    // Next coordinates with a carry bit so a wide grid cannot wrap silently.
    always_comb begin
        nx = {1'b0, pos.x} + STEP;
        ny = {1'b0, pos.y} + 1'b1;
        nz = {1'b0, pos.z} + 1'b1;
        x_wrap = nx >= {1'b0, grid.x};
        y_wrap = ny >= {1'b0, grid.y};
        z_wrap = nz >= {1'b0, grid.z};
    end

    // Position, pending flag, busy and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            have <= 1'b0;
            busy <= 1'b0;
            done <= 1'b0;
        end else if (go) begin
            pos  <= '0;
            have <= (grid.x != '0) && (grid.y != '0) && (grid.z != '0);
            busy <= 1'b1;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (take && have) begin
                if (!x_wrap) begin
                    pos.x <= nx[WORD_W-1:0];
                end else begin
                    pos.x <= '0;
                    if (!y_wrap) begin
                        pos.y <= ny[WORD_W-1:0];
                    end else begin
                        pos.y <= '0;
                        if (!z_wrap) pos.z <= nz[WORD_W-1:0];
                        else         have  <= 1'b0;
                    end
                end
            end
            if (busy && !have && all_idle) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdc_threads.sv
// Thread table: picks the lowest idle thread for a pending item, holds each
// thread's enable and metadata, and serves metadata over the IO read port.
// Assumes a thread halts only itself and only while enabled.
module wdc_threads
    import wdc_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int TIDW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              have,
    input  triple_t           pos,
    input  triple_t           grp,
    input  logic [NTHR-1:0]   halt,
    output logic [NTHR-1:0]   thr_en,
    output logic [NTHR-1:0]   thr_start,
    output logic              take,
    output logic              all_idle,
    input  logic              io_rd,
    input  logic [TIDW-1:0]   io_tid,
    input  logic [2:0]        io_fld,
    output logic [WORD_W-1:0] io_rdata,
    output logic              io_rvalid
);
    logic            found;
    logic [TIDW-1:0] sel;
    triple_t [NTHR-1:0] pos_all;
    triple_t [NTHR-1:0] dim_all;
    logic [WORD_W-1:0]  fmux;

    // Lowest-index idle thread search.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = NTHR-1; i >= 0; i--) begin
            if (!thr_en[i]) begin
                found = 1'b1;
                sel   = TIDW'(i);
            end
        end
    end

    assign take     = have && found;
    assign all_idle = (thr_en == '0);

    generate
        for (genvar g = 0; g < NTHR; g++) begin : g_thr
            logic    en_q, st_q;
            triple_t pos_q, dim_q;

            // Per-thread enable, start pulse and latched metadata.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q  <= 1'b0;
                    st_q  <= 1'b0;
                    pos_q <= '0;
                    dim_q <= '0;
                end else begin
                    st_q <= take && (sel == TIDW'(g));
                    if (take && (sel == TIDW'(g))) begin
                        en_q  <= 1'b1;
                        pos_q <= pos;
                        dim_q <= grp;
                    end else if (halt[g]) begin
                        en_q <= 1'b0;
                    end
                end
            end

            assign thr_en[g]    = en_q;
            assign thr_start[g] = st_q;
            assign pos_all[g]   = pos_q;
            assign dim_all[g]   = dim_q;
        end
    endgenerate

    // Metadata field selection for the IO read port.
    always_comb begin
        case (io_fld)
            3'd0:    fmux = pos_all[io_tid].x;
            3'd1:    fmux = pos_all[io_tid].y;
            3'd2:    fmux = pos_all[io_tid].z;
            3'd3:    fmux = dim_all[io_tid].x;
            3'd4:    fmux = dim_all[io_tid].y;
            3'd5:    fmux = dim_all[io_tid].z;
            default: fmux = '0;
        endcase
    end

    // IO read data register, one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_rvalid <= 1'b0;
            io_rdata  <= '0;
        end else begin
            io_rvalid <= io_rd;
            if (io_rd) io_rdata <= fmux;
        end
    end
endmodule

// File: rtl/witem_dispatch.sv
// Top of the work-item dispatch controller: register file, grid walker and
// thread table. Assumes threads retire only through thr_halt.
module witem_dispatch
    import wdc_pkg::*;
#(
    parameter int NTHR  = 4,
    parameter int LANES = 16,
    parameter int TIDW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [WORD_W-1:0] s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [WORD_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [NTHR-1:0]   thr_en,
    output logic [NTHR-1:0]   thr_start,
    input  logic [NTHR-1:0]   thr_halt,
    output logic [WORD_W-1:0] start_pc,
    input  logic              io_rd,
    input  logic [TIDW-1:0]   io_tid,
    input  logic [2:0]        io_fld,
    output logic [WORD_W-1:0] io_rdata,
    output logic              io_rvalid,
    output logic              done_irq
);
    disp_cfg_t cfg;
    triple_t   cur_pos;
    logic      go_w, busy_w, have_w, take_w, idle_w;

    assign start_pc = cfg.pc;

    wdc_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .awaddr  (s_awaddr),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .wdata   (s_wdata),
        .wstrb   (s_wstrb),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .bresp   (s_bresp),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .araddr  (s_araddr),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .rdata   (s_rdata),
        .rresp   (s_rresp),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .busy    (busy_w),
        .cfg     (cfg),
        .go      (go_w)
    );

    wdc_walker #(.LANES(LANES)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go_w),
        .grid     (cfg.grid),
        .take     (take_w),
        .all_idle (idle_w),
        .have     (have_w),
        .pos      (cur_pos),
        .busy     (busy_w),
        .done     (done_irq)
    );

    wdc_threads #(.NTHR(NTHR), .TIDW(TIDW)) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .have      (have_w),
        .pos       (cur_pos),
        .grp       (cfg.grp),
        .halt      (thr_halt),
        .thr_en    (thr_en),
        .thr_start (thr_start),
        .take      (take_w),
        .all_idle  (idle_w),
        .io_rd     (io_rd),
        .io_tid    (io_tid),
        .io_fld    (io_fld),
        .io_rdata  (io_rdata),
        .io_rvalid (io_rvalid)
    );
endmodule

// File: rtl/wdc_checker.sv
// Protocol and ordering properties of the dispatch controller, bound to the top.
module wdc_checker #(
    parameter int NTHR = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NTHR-1:0] thr_en,
    input logic [NTHR-1:0] thr_start,
    input logic [NTHR-1:0] thr_halt,
    input logic            done_irq,
    input logic            busy,
    input logic            bvalid,
    input logic            bready,
    input logic            rvalid,
    input logic            rready
);
    p_one_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(thr_start));

    p_start_was_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_start != '0) |-> ((thr_start & $past(thr_en)) == '0));

    p_start_enables_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_start != '0) |-> ((thr_start & ~thr_en) == '0));

    p_halt_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((thr_halt & thr_en) != '0) |=> (($past(thr_halt & thr_en) & thr_en) == '0));

    p_no_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (thr_start == '0));

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    p_irq_all_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> ((thr_en == '0) && !busy));

    p_bresp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> rvalid);
endmodule

bind witem_dispatch wdc_checker #(.NTHR(NTHR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .thr_en    (thr_en),
    .thr_start (thr_start),
    .thr_halt  (thr_halt),
    .done_irq  (done_irq),
    .busy      (busy_w),
    .bvalid    (s_bvalid),
    .bready    (s_bready),
    .rvalid    (s_rvalid),
    .rready    (s_rready)
);

// File: tb/witem_dispatch_test.sv
// Scoreboard bench: the launch task queues expected items, the start monitor
// queues started threads, and a thread model reads metadata back and retires.
module witem_dispatch_test;
    localparam int CLK_PERIOD = 10;
    localparam int NTHR = 4;
    localparam int TIDW = 2;

    typedef struct {
        int unsigned x;
        int unsigned y;
        int unsigned z;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] awaddr = '0, araddr = '0;
    logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0] wstrb = '0;
    logic bready = 1'b1, rready = 1'b1;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;
    logic [31:0] rdata;
    logic [NTHR-1:0] thr_en, thr_start;
    logic [NTHR-1:0] thr_halt = '0;
    logic [31:0] start_pc;
    logic io_rd = 1'b0;
    logic [TIDW-1:0] io_tid = '0;
    logic [2:0] io_fld = '0;
    logic [31:0] io_rdata;
    logic io_rvalid, done_irq;

    int checks = 0, errors = 0;
    int irq_cnt = 0, start_cnt = 0;
    exp_item_t exp_q[$];
    int tid_q[$];
    logic [NTHR-1:0] busy_m = '0;
    logic [31:0] exp_pc = '0;
    logic [31:0] exp_l[3];

    always #(CLK_PERIOD/2) clk = ~clk;

    witem_dispatch #(.NTHR(NTHR), .LANES(16)) uut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .thr_en(thr_en), .thr_start(thr_start), .thr_halt(thr_halt),
        .start_pc(start_pc),
        .io_rd(io_rd), .io_tid(io_tid), .io_fld(io_fld),
        .io_rdata(io_rdata), .io_rvalid(io_rvalid),
        .done_irq(done_irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic axi_write(input logic [5:0] a, input logic [31:0] d,
                             input logic [3:0] s);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        check(bvalid && bresp == 2'b00, "R1 write response", {30'b0, bresp}, 32'h0);
        @(negedge clk);
    endtask

    task automatic axi_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        @(negedge clk);
        arvalid = 1'b0;
        d = rdata;
        check(rvalid && rresp == 2'b00, "R1 read valid", {31'b0, rvalid}, 32'h1);
        @(negedge clk);
    endtask

    task automatic read_expect(input logic [5:0] a, input logic [31:0] e,
                               input string req);
        logic [31:0] v;
        axi_read(a, v);
        check(v == e, req, v, e);
    endtask

    // Start monitor: compares each thread start with the occupancy model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_irq) irq_cnt++;
            if (thr_start != '0) begin
                int want;
                int got;
                want = -1;
                got = -1;
                for (int i = NTHR-1; i >= 0; i--) if (!busy_m[i]) want = i;
                for (int i = 0; i < NTHR; i++) if (thr_start[i]) got = i;
                check($countones(thr_start) == 1, "R4 single start",
                      32'(thr_start), 32'h1);
                check(got == want, "R4 lowest idle thread", 32'(got), 32'(want));
                check(thr_en[got], "R4 enable rises", 32'(thr_en), 32'(1 << got));
                check(start_pc == exp_pc, "R11 entry address", start_pc, exp_pc);
                busy_m[got] = 1'b1;
                tid_q.push_back(got);
                start_cnt++;
            end
        end
    end

    // Thread model: read metadata of each started thread, then retire it.
    initial begin
        forever begin
            int t;
            exp_item_t e;
            logic [31:0] ev[6];
            while (tid_q.size() == 0) @(negedge clk);
            t = tid_q.pop_front();
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected extra item", 32'(t), 32'hFFFFFFFF);
                e = '{x: 0, y: 0, z: 0};
            end else begin
                e = exp_q.pop_front();
            end
            ev[0] = e.x; ev[1] = e.y; ev[2] = e.z;
            ev[3] = exp_l[0]; ev[4] = exp_l[1]; ev[5] = exp_l[2];
            for (int f = 0; f < 7; f++) begin
                logic [31:0] want;
                want = (f < 6) ? ev[f] : 32'h0;
                @(negedge clk);
                io_rd = 1'b1; io_tid = TIDW'(t); io_fld = 3'(f);
                @(negedge clk);
                io_rd = 1'b0;
                check(io_rvalid && io_rdata == want,
                      (f < 3) ? "R3 item coordinate via R6 port" : "R6 metadata field",
                      io_rdata, want);
            end
            @(negedge clk);
            thr_halt[t] = 1'b1;
            @(negedge clk);
            thr_halt[t] = 1'b0;
            check(!thr_en[t], "R5 halt clears enable", 32'(thr_en), 32'h0);
            #1 busy_m[t] = 1'b0;
        end
    end

    // Run one launch: load descriptor, queue expected items, ring, wait for done.
    task automatic launch(input int gx, input int gy, input int gz,
                          input logic [31:0] pc, input bit poke_busy,
                          input logic [31:0] stat_after);
        int base_irq, base_start, n, wait_cyc;
        n = 0;
        axi_write(6'h00, pc, 4'hF);
        axi_write(6'h04, 32'(gx), 4'hF);
        axi_write(6'h08, 32'(gy), 4'hF);
        axi_write(6'h0C, 32'(gz), 4'hF);
        axi_write(6'h10, 32'd16, 4'hF);
        axi_write(6'h14, 32'd2, 4'hF);
        axi_write(6'h18, 32'd3, 4'hF);
        exp_pc = pc;
        exp_l[0] = 32'd16; exp_l[1] = 32'd2; exp_l[2] = 32'd3;
        for (int z = 0; z < gz; z++)
            for (int y = 0; y < gy; y++)
                for (int x = 0; x < gx; x += 16) begin
                    exp_q.push_back('{x: x, y: y, z: z});
                    n++;
                end
        base_irq = irq_cnt;
        base_start = start_cnt;
        axi_write(6'h1C, 32'h1, 4'hF);
        if (poke_busy) begin
            read_expect(6'h20, 32'h1, "R2 busy after doorbell");
            axi_write(6'h1C, 32'h1, 4'hF);
            axi_write(6'h04, 32'd7, 4'hF);
            read_expect(6'h20, 32'h3, "R8 error set by busy doorbell");
            read_expect(6'h04, 32'(gx), "R9 config write ignored while busy");
        end
        wait_cyc = 0;
        while (irq_cnt == base_irq && wait_cyc < 20000) begin
            @(negedge clk);
            wait_cyc++;
        end
        repeat (4) @(negedge clk);
        check(irq_cnt == base_irq + 1, "R7 single completion pulse",
              32'(irq_cnt - base_irq), 32'h1);
        check(start_cnt - base_start == n, "R3 item count",
              32'(start_cnt - base_start), 32'(n));
        check(exp_q.size() == 0, "R3 all expected items consumed",
              32'(exp_q.size()), 32'h0);
        check(thr_en == '0, "R7 threads idle at completion", 32'(thr_en), 32'h0);
        read_expect(6'h20, stat_after, "R7 busy cleared");
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(thr_en == '0 && thr_start == '0, "R4 reset threads idle",
              32'(thr_en), 32'h0);
        check(!done_irq, "R7 reset no irq", 32'(done_irq), 32'h0);
        read_expect(6'h20, 32'h0, "R1 reset status");
        read_expect(6'h00, 32'h0, "R1 reset entry address");

        // R1: plain and byte-strobed writes read back.
        axi_write(6'h00, 32'hCAFE_0100, 4'hF);
        read_expect(6'h00, 32'hCAFE_0100, "R1 entry readback");
        axi_write(6'h08, 32'h1122_3344, 4'hF);
        axi_write(6'h08, 32'hFFFF_FF05, 4'h1);
        read_expect(6'h08, 32'h1122_3305, "R1 byte strobe merge");
        read_expect(6'h1C, 32'h0, "R1 doorbell reads zero");

        // R2 R3 R4 R5 R6 R7 R11: small 2-D launch.
        launch(40, 2, 1, 32'h0000_1000, 1'b0, 32'h0);
        // R8 R9: large launch with a doorbell and a config write while busy.
        launch(100, 3, 2, 32'h0000_2400, 1'b1, 32'h2);
        axi_write(6'h20, 32'h0, 4'hF);
        read_expect(6'h20, 32'h0, "R8 status write clears error");
        // R3: Z ordering with a single X item per row.
        launch(16, 1, 3, 32'h0000_3000, 1'b0, 32'h0);
        // R10: empty grid.
        launch(5, 0, 2, 32'h0000_4000, 1'b0, 32'h0);

        axi_read(6'h00, v);
        check(v == 32'h0000_4000 && start_pc == v, "R11 start_pc follows entry",
              start_pc, 32'h0000_4000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule